// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial bus. It gives a host access to a 512 x 8 memory array that sits outside the block. The block samples SCL and SDA in its own clock domain and detects START and STOP conditions. It matches the device-select byte and drives the acknowledge through an SDA pull-down enable. It keeps the 9-bit word address counter. Bit 8 of that address travels in the device-select byte. The other eight bits arrive as the word-address byte.

Writes go into a 16-byte page buffer. The write address wraps inside the page. A STOP that ends a write with at least one data byte starts a self-timed busy period. During that period the bus is ignored and no acknowledge is given, so the host finds completion by polling. When the period ends, the block copies the buffered bytes into the array, one per clock.

Reads have three forms:
- A current-address read uses the counter as it stands.
- A random read first sends a write that carries only the address, then a repeated START with the read bit set.
- A sequential read continues for as long as the host acknowledges each byte, and the address rolls over at the end of the array.

A supply-good input and a write-lock input come from outside the block.

Top module: `ser_mem_slave`

## Requirements
- R1: While reset is held and right after it, the SDA pull-down is off and the array write strobe is low.
- R2: The block accepts a device-select byte only if bits 7:4 are 1010 and bits 3:2 are 00. Bit 1 gives word-address bit 8 and bit 0 gives the direction (1 = read). A byte that does not match gets no acknowledge, and the bus is then ignored until the next START.
- R3: The block pulls SDA low for the ninth clock after each of these: a matched device byte, the word-address byte, and every write data byte. The pull-down only starts while SCL is low.
- R4: Write data bytes go to the page buffer at word-address bits 3:0. This index counts up and wraps from 15 to 0 without touching bits 8:4. If more than 16 bytes arrive, the earlier ones are overwritten.
- R5: A STOP that ends a write with at least one data byte makes the block busy for BUSY_CYCLES + 16 clocks. While busy, the block acknowledges nothing, including a device byte sent to poll it.
- R6: The array is written only at the end of the busy period. It gets one strobe per clock, and only for the buffer positions that received data, all within one page. The array keeps its old contents until then.
- R7: A random read returns the byte at the 9-bit address that was just loaded by the address-only write.
- R8: Each byte sent to the host advances the address counter. A current-address read starts at the counter, and the matched device byte replaces bit 8 of the counter.
- R9: The host acknowledges a byte by driving SDA low on the ninth clock. After that acknowledge the next byte follows, and the address goes from 0x1FF to 0x000. If the host does not acknowledge, the read ends and SDA is released.
- R10: If the write-lock input is high at the STOP, nothing is committed and no busy period follows.
- R11: While supply-good is low, the block gives no acknowledge. Any transfer in progress is dropped, along with its buffered write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock that samples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| sda_pd_o | output | 1 | High pulls the data line low |
| supply_ok_i | input | 1 | Low means the supply is below the trip level |
| wr_lock_i | input | 1 | High blocks the commit of a write |
| mem_addr_o | output | 9 | Array address (read address, or commit address while busy) |
| mem_we_o | output | 1 | Array write strobe |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data, same cycle as the address |

## Verification
Every SCL edge reaches the control logic two clocks after it appears at the pin. The pull-down responds on the clock after that, so it changes three clocks after a falling SCL. The bench holds each bus phase for six clocks and samples SDA at the end of the SCL-high phase, which is well after that latency. The first array strobe arrives about BUSY_CYCLES plus four clocks after the SDA rise of the STOP, offset by the buffer index of the first stored byte. The bench checks that delay inside a window. It waits longer than the whole busy period before it polls for the acknowledge that marks completion or reads the array.

// File: rtl/sms_pkg.sv
`timescale 1ns/1ps
package sms_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = DATA_W + 1;
  typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_ADDR, PH_WDATA, PH_RDATA} phase_e;
endpackage

// File: rtl/sms_bus_sync.sv
`timescale 1ns/1ps
module sms_bus_sync #(
  parameter int STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int N = STAGES - 1;
  logic [N:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[N-1:0], scl_i};
      sda_q <= {sda_q[N-1:0], sda_i};
    end
  end

  assign scl_o      = scl_q[N-1];
  assign sda_o      = sda_q[N-1];
  assign scl_rise_o = scl_q[N-1] & ~scl_q[N];
  assign scl_fall_o = ~scl_q[N-1] & scl_q[N];
  assign start_o    = scl_q[N-1] & scl_q[N] & ~sda_q[N-1] & sda_q[N];
  assign stop_o     = scl_q[N-1] & scl_q[N] & sda_q[N-1] & ~sda_q[N];
endmodule

// File: rtl/sms_page_buf.sv
`timescale 1ns/1ps
module sms_page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PAGE_W-1:0] ridx_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvld_o,
  output logic              any_o
);
  localparam int DEPTH = 1 << PAGE_W;
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) data_q[widx_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vld_q <= '0;
    else if (clr_i) vld_q <= '0;
    else if (wr_i)  vld_q[widx_i] <= 1'b1;
  end

  assign rdata_o = data_q[ridx_i];
  assign rvld_o  = vld_q[ridx_i];
  assign any_o   = |vld_q;
endmodule

// File: rtl/sms_busy_timer.sv
`timescale 1ns/1ps
module sms_busy_timer #(
  parameter int BUSY_CYCLES = 5000,
  parameter int PAGE_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  output logic              busy_o,
  output logic              commit_o,
  output logic [PAGE_W-1:0] idx_o,
  output logic              done_o
);
  localparam int TOTAL = BUSY_CYCLES + (1 << PAGE_W);
  localparam int CW    = $clog2(TOTAL + 1);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] rel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (cnt_q == '0 && go_i)     cnt_q <= CW'(1);
    else if (cnt_q == CW'(TOTAL))     cnt_q <= '0;
    else if (cnt_q != '0)             cnt_q <= cnt_q + CW'(1);
  end

  assign rel      = cnt_q - CW'(BUSY_CYCLES + 1);
  assign busy_o   = cnt_q != '0;
  assign commit_o = cnt_q > CW'(BUSY_CYCLES);
  assign idx_o    = rel[PAGE_W-1:0];
  assign done_o   = cnt_q == CW'(TOTAL);
endmodule

// File: rtl/ser_mem_slave.sv
`timescale 1ns/1ps
module ser_mem_slave
  import sms_pkg::*;
#(
  parameter int          BUSY_CYCLES = 5000,
  parameter int          PAGE_W      = 4,
  parameter logic [3:0]  DEV_CODE    = 4'hA,
  parameter logic [1:0]  DEV_SEL     = 2'b00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pd_o,
  input  logic              supply_ok_i,
  input  logic              wr_lock_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int HI = ADDR_W - 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, commit, done, live, go, buf_wr, buf_clr, buf_rvld, buf_any;
  logic [PAGE_W-1:0] cidx;
  logic [DATA_W-1:0] buf_rdata;

  phase_e            phase_q;
  logic [3:0]        cnt_q;
  logic [DATA_W-1:0] sh_q, tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rw_q, mack_q, pd_q;
  logic              dev_match;

  sms_bus_sync #(.STAGES(3)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  sms_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_W(PAGE_W)) u_timer (
    .clk_i, .rst_ni, .go_i(go), .busy_o(busy), .commit_o(commit),
    .idx_o(cidx), .done_o(done)
  );

  sms_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .wr_i(buf_wr),
    .widx_i(addr_q[PAGE_W-1:0]), .wdata_i(sh_q), .ridx_i(cidx),
    .rdata_o(buf_rdata), .rvld_o(buf_rvld), .any_o(buf_any)
  );

  assign live      = supply_ok_i & ~busy;
  assign dev_match = (sh_q[7:4] == DEV_CODE) && (sh_q[3:2] == DEV_SEL);
  assign go        = live & stop_evt & buf_any & ~wr_lock_i;
  assign buf_wr    = live & ~stop_evt & ~start_evt & scl_fall &
                     (phase_q == PH_WDATA) & (cnt_q == 4'd8);
  // abort, commit end, new transfer, or a locked write all flush the page
  assign buf_clr   = ~supply_ok_i | done | (live & start_evt) |
                     (live & stop_evt & wr_lock_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      pd_q    <= 1'b0;
    end else if (!live || stop_evt) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pd_q    <= 1'b0;
    end else if (start_evt) begin
      phase_q <= PH_DEV;
      cnt_q   <= '0;
      pd_q    <= 1'b0;
    end else if (scl_rise && phase_q != PH_IDLE) begin
      if (cnt_q < 4'd8) begin
        if (phase_q != PH_RDATA) sh_q <= {sh_q[DATA_W-2:0], sda_s};
        cnt_q <= cnt_q + 4'd1;
      end else if (cnt_q == 4'd8) begin
        cnt_q  <= 4'd9;
        mack_q <= ~sda_s;
      end
    end else if (scl_fall && phase_q != PH_IDLE) begin
      if (cnt_q == 4'd8) begin
        unique case (phase_q)
          PH_DEV: begin
            if (dev_match) begin
              pd_q       <= 1'b1;
              addr_q[HI] <= sh_q[1];
              rw_q       <= sh_q[0];
            end else begin
              phase_q <= PH_IDLE;
            end
          end
          PH_ADDR: begin
            pd_q              <= 1'b1;
            addr_q[HI-1:0]    <= sh_q;
          end
          PH_WDATA: begin
            pd_q                   <= 1'b1;
            addr_q[PAGE_W-1:0]     <= addr_q[PAGE_W-1:0] + PAGE_W'(1);
          end
          default: pd_q <= 1'b0;
        endcase
      end else if (cnt_q == 4'd9) begin
        cnt_q <= '0;
        unique case (phase_q)
          PH_DEV: begin
            if (rw_q) begin
              phase_q <= PH_RDATA;
              tx_q    <= mem_rdata_i;
              pd_q    <= ~mem_rdata_i[DATA_W-1];
              addr_q  <= addr_q + ADDR_W'(1);
            end else begin
              phase_q <= PH_ADDR;
              pd_q    <= 1'b0;
            end
          end
          PH_ADDR:  begin phase_q <= PH_WDATA; pd_q <= 1'b0; end
          PH_WDATA: pd_q <= 1'b0;
          default: begin
            if (mack_q) begin
              tx_q   <= mem_rdata_i;
              pd_q   <= ~mem_rdata_i[DATA_W-1];
              addr_q <= addr_q + ADDR_W'(1);
            end else begin
              phase_q <= PH_IDLE;
              pd_q    <= 1'b0;
            end
          end
        endcase
      end else if (phase_q == PH_RDATA) begin
        pd_q <= ~tx_q[DATA_W-2];
        tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign sda_pd_o    = pd_q;
  assign mem_addr_o  = commit ? {addr_q[HI:PAGE_W], cidx} : addr_q;
  assign mem_we_o    = commit & buf_rvld;
  assign mem_wdata_o = buf_rdata;
endmodule

// File: rtl/sms_chk.sv
`timescale 1ns/1ps
module sms_chk #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              busy,
  input logic              commit,
  input logic              sda_pd_o,
  input logic              supply_ok_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  a_r3_ack_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pd_o) |-> !scl_s);

  a_r5_busy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_pd_o);

  a_r6_we_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy);

  a_r6_one_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && $past(commit)) |-> (mem_addr_o[ADDR_W-1:PAGE_W] == $past(mem_addr_o[ADDR_W-1:PAGE_W])));

  a_r11_supply_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !sda_pd_o);
endmodule

bind ser_mem_slave sms_chk #(.ADDR_W(sms_pkg::ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .busy(busy), .commit(commit),
  .sda_pd_o(sda_pd_o), .supply_ok_i(supply_ok_i), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o)
);

// File: tb/sim_ser_mem_slave.sv
`timescale 1ns/1ps
module sim_ser_mem_slave;
  localparam int BUSY = 600;
  localparam int H    = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, sok = 1'b1, lock = 1'b0;
  logic       pd, we;
  logic [8:0] maddr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [512];
  logic [7:0] em  [512];
  int cyc = 0, we_total = 0, snap = 0, t_first = 0, t0 = 0;
  int checks = 0, errors = 0;
  wire sda_line = sda_m & ~pd;

  always #2.5 clk = ~clk;

  ser_mem_slave #(.BUSY_CYCLES(BUSY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pd_o(pd),
    .supply_ok_i(sok), .wr_lock_i(lock), .mem_addr_o(maddr), .mem_we_o(we),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  assign rdata = mem[maddr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int a = 0; a < 512; a++) mem[a] <= 8'(a * 13 + 7);
    end else if (we) begin
      mem[maddr] <= wdata;
      if (we_total == snap) t_first <= cyc;
      we_total <= we_total + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n); repeat (n) @(negedge clk); endtask

  task automatic b_start;
    scl = 0; hw(H); sda_m = 1; hw(H); scl = 1; hw(H); sda_m = 0; hw(H); scl = 0; hw(H);
  endtask

  task automatic b_stop;
    scl = 0; hw(H); sda_m = 0; hw(H); scl = 1; hw(H); sda_m = 1; t0 = cyc; hw(H);
  endtask

  task automatic b_bit(input logic b, output logic s);
    sda_m = b; hw(H); scl = 1; hw(H); s = sda_line; hw(H); scl = 0; hw(H);
  endtask

  task automatic b_wr(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) b_bit(d[i], s);
    b_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic b_rd(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin b_bit(1'b1, s); d[i] = s; end
    b_bit(!mack, s);
  endtask

  task automatic rand_read(input logic [8:0] a, output logic [7:0] d);
    logic ack;
    b_start; b_wr({7'b1010000, 1'b0} | {6'd0, a[8], 1'b0}, ack); chk("R7 dev ack", ack, 1);
    b_wr(a[7:0], ack); chk("R7 addr ack", ack, 1);
    b_start; b_wr(8'hA1 | {6'd0, a[8], 1'b0}, ack); chk("R7 read dev ack", ack, 1);
    b_rd(1'b0, d); b_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run cycles=%0d expected < %0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int dly;
    for (int a = 0; a < 512; a++) em[a] = 8'(a * 13 + 7);
    hw(5);
    chk("R1 pd in reset", pd, 0);
    chk("R1 we in reset", we, 0);
    rst_n = 1; hw(5);
    chk("R1 pd after reset", pd, 0);

    // R2: wrong code, wrong select bits
    b_start; b_wr(8'hB0, ack); chk("R2 code B0 no ack", ack, 0);
    b_wr(8'h00, ack); chk("R2 ignored until START", ack, 0); b_stop;
    b_start; b_wr(8'hA4, ack); chk("R2 sel bits no ack", ack, 0); b_stop;

    // R3 R5 R6: byte write at 0x1F5
    snap = we_total;
    b_start; b_wr(8'hA2, ack); chk("R3 dev ack", ack, 1);
    b_wr(8'hF5, ack); chk("R3 addr ack", ack, 1);
    b_wr(8'h5C, ack); chk("R3 data ack", ack, 1);
    b_stop; dly = t0;
    em[9'h1F5] = 8'h5C;
    chk("R6 array unchanged after STOP", mem[9'h1F5], 8'(9'h1F5 * 13 + 7));
    b_start; b_wr(8'hA0, ack); chk("R5 poll while busy", ack, 0); b_stop;
    hw(BUSY + 60);
    chk("R6 one strobe", we_total - snap, 1);
    chk("R6 commit delay window", int'((t_first - dly) >= BUSY && (t_first - dly) <= BUSY + 24), 1);
    b_start; b_wr(8'hA0, ack); chk("R5 poll after busy", ack, 1); b_stop;
    chk("R6 array written", mem[9'h1F5], 8'h5C);

    // R7 random read, R8 current address read
    rand_read(9'h1F5, d); chk("R7 random read 1F5", d, 8'h5C);
    b_start; b_wr(8'hA3, ack); chk("R8 dev ack", ack, 1);
    b_rd(1'b0, d); b_stop; chk("R8 current read 1F6", d, em[9'h1F6]);
    b_start; b_wr(8'hA1, ack); b_rd(1'b0, d); b_stop;
    chk("R8 bit8 replaced 0F7", d, em[9'h0F7]);

    // R4 page write of 20 bytes from 0x03A
    snap = we_total;
    b_start; b_wr(8'hA0, ack); b_wr(8'h3A, ack);
    for (int k = 0; k < 20; k++) begin
      b_wr(8'(8'h80 + k), ack); chk("R4 page data ack", ack, 1);
      em[9'h030 + ((10 + k) & 15)] = 8'(8'h80 + k);
    end
    b_stop; hw(BUSY + 60);
    chk("R6 page strobes", we_total - snap, 16);
    b_start; b_wr(8'hA0, ack); b_wr(8'h30, ack); b_start; b_wr(8'hA1, ack);
    for (int k = 0; k < 16; k++) begin
      b_rd(k != 15, d); chk("R4 page wrap content", d, em[9'h030 + k]);
    end
    b_stop;

    // R9 rollover and NACK end
    b_start; b_wr(8'hA2, ack); b_wr(8'hFE, ack); b_start; b_wr(8'hA3, ack);
    b_rd(1'b1, d); chk("R9 seq 1FE", d, em[9'h1FE]);
    b_rd(1'b1, d); chk("R9 seq 1FF", d, em[9'h1FF]);
    b_rd(1'b0, d); chk("R9 rollover 000", d, em[9'h000]);
    chk("R9 released after nack", pd, 0);
    b_stop;

    // R10 write lock
    snap = we_total; lock = 1;
    b_start; b_wr(8'hA0, ack); b_wr(8'h60, ack); b_wr(8'h22, ack); b_stop;
    hw(4); lock = 0;
    b_start; b_wr(8'hA0, ack); chk("R10 no busy after locked write", ack, 1); b_stop;
    hw(BUSY + 60);
    chk("R10 no strobe", we_total - snap, 0);
    chk("R10 array kept", mem[9'h060], em[9'h060]);

    // R11 supply drop aborts transfer
    snap = we_total;
    b_start; b_wr(8'hA0, ack); b_wr(8'h50, ack); b_wr(8'h11, ack);
    sok = 0; hw(20); chk("R11 pd low on supply drop", pd, 0);
    sok = 1; hw(5); b_stop;
    b_start; b_wr(8'hA0, ack); chk("R11 not busy after abort", ack, 1); b_stop;
    hw(BUSY + 60);
    chk("R11 no strobe after abort", we_total - snap, 0);
    chk("R11 array kept", mem[9'h050], em[9'h050]);
    sok = 0;
    b_start; b_wr(8'hA0, ack); chk("R11 no ack under low supply", ack, 0); b_stop;
    sok = 1; hw(10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule